// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block arbitrates five maskable interrupt sources for a small 8-bit processor core. Each source has a request line and an enable bit. A pending bit is latched for each source on the rising edge of its request. A global interrupt enable gates whether the core may be interrupted at all. Source priorities are fixed. The highest is the PWM timer (index 4), followed by the software interrupt (3), timer 0 (2) and the converter (1). The multi-input wakeup (index 0) is the lowest.

When the global enable is one and at least one enabled source is pending, the block raises a registered take request toward the core. With it comes the index of the winning vector. The index is frozen for the whole entry sequence. The core answers with a strobe once the program counter is stacked and the vector fetched. That strobe ends the entry and clears the global enable. A return-from-interrupt strobe sets the enable back to one. Software may set or clear the enable at any time. Setting it inside a handler lets another pending interrupt nest. The handler clears its pending bit through an indexed acknowledge or a software clear mask.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_take_o`, `gie_o`, `pend_o` and `vec_idx_o` are all zero.
- R2: A pending bit is set one cycle after the cycle in which its request input goes from 0 to 1, whatever the global enable and per-source enable are. A request held high sets its bit only once.
- R3: `pend_o[i]` clears one cycle after `ack_i` with `ack_idx_i == i`, or after `pend_clr_i[i]` is 1. An acknowledge index of 5 or more clears nothing. If a rising request edge and a clear for the same source meet in one cycle, the bit stays set.
- R4: The global enable is set by `gie_set_i` or `reti_i` and cleared by `gie_clr_i`. When both set and clear arrive in one cycle, set wins. The change is visible one cycle later.
- R5: While `gie_o` is 0, `irq_take_o` never rises, even when enabled sources are pending.
- R6: When no entry is in progress, `gie_o` is 1, and some source is pending with its `src_en_i` bit set, `irq_take_o` rises one cycle later. `vec_idx_o` then holds the highest such index (4 = PWM timer, 3 = software, 2 = timer 0, 1 = converter, 0 = wakeup). Pending sources whose enable is 0 are never chosen.
- R7: While `irq_take_o` is 1, `vec_idx_o` stays unchanged, even if a higher-priority request arrives.
- R8: `vec_done_i` while `irq_take_o` is 1 drops `irq_take_o` and `gie_o` to 0 one cycle later. This overrides a `reti_i` or `gie_set_i` in the same cycle. `vec_done_i` while `irq_take_o` is 0 has no effect.
- R9: Setting the global enable after an entry has completed starts a new entry for the highest remaining pending, enabled source. This is how a handler allows nesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 5 | Request lines, bit 4 highest priority |
| src_en_i | input | 5 | Per-source enables |
| ack_i | input | 1 | Acknowledge strobe for the source in `ack_idx_i` |
| ack_idx_i | input | 3 | Index of the source being acknowledged |
| pend_clr_i | input | 5 | Software clear mask for pending bits |
| gie_set_i | input | 1 | Software set of global enable |
| gie_clr_i | input | 1 | Software clear of global enable |
| reti_i | input | 1 | Return-from-interrupt strobe |
| vec_done_i | input | 1 | PC stacked and vector fetched strobe |
| irq_take_o | output | 1 | Interrupt entry request to the core |
| vec_idx_o | output | 3 | Selected vector index |
| gie_o | output | 1 | Global interrupt enable |
| pend_o | output | 5 | Pending bits |

## Verification
Every piece of state is a register that drives a port, either directly or through a one-level selection. A corrupted pending bit, enable flag or frozen index shows at `pend_o`, `gie_o` or `vec_idx_o` on the next cycle. A wrong entry decision shows as a take pulse that starts or ends one cycle early or late. A behavioural model of the same rules is compared against all four outputs on every cycle. A single-cycle divergence is therefore reported where it first appears, through directed sequences and a long random run.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  // Number of maskable sources handled by the controller
  localparam int SRC_COUNT = 5;

  // Source index doubles as priority: larger index wins
  typedef enum logic [2:0] {
    SRC_WAKEUP = 3'd0,
    SRC_CONV   = 3'd1,
    SRC_TMR0   = 3'd2,
    SRC_SOFT   = 3'd3,
    SRC_PWM    = 3'd4
  } src_id_e;

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);

  logic [N-1:0] req_q;
  logic [N-1:0] pend_q;

  for (genvar g = 0; g < N; g++) begin : g_src
    logic rise;
    assign rise = req_i[g] & ~req_q[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        req_q[g]  <= 1'b0;
        pend_q[g] <= 1'b0;
      end else begin
        req_q[g] <= req_i[g];
        if (rise)
          pend_q[g] <= 1'b1;
        else if (clr_i[g])
          pend_q[g] <= 1'b0;
      end
    end

    // R2: a pending bit only appears after its request was high
    a_r2_pend_from_req: assert property (@(posedge clk) disable iff (rst)
      $rose(pend_q[g]) |-> $past(req_i[g]));

    // R3: edge and clear together leave the bit set
    a_r3_edge_beats_clear: assert property (@(posedge clk) disable iff (rst)
      (rise && clr_i[g]) |=> pend_q[g]);

    // R3: a clear without an edge empties the bit
    a_r3_clear_takes: assert property (@(posedge clk) disable iff (rst)
      (clr_i[g] && !req_i[g]) |=> !pend_q[g]);
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 5,
  parameter int W = 3
) (
  input  logic [N-1:0] cand_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);

  // Ascending scan: a later (higher) index overrides a lower one
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (cand_i[i]) idx_o = W'(i);
    end
  end

  assign any_o = |cand_i;

endmodule

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cand_any_i,
  input  logic [W-1:0] cand_idx_i,
  input  logic         vec_done_i,
  input  logic         reti_i,
  input  logic         gie_set_i,
  input  logic         gie_clr_i,
  output logic         gie_o,
  output logic         take_o,
  output logic [W-1:0] vec_o
);

  logic         gie_q;
  logic         take_q;
  logic [W-1:0] vec_q;
  logic         finish;

  assign finish = take_q & vec_done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie_q  <= 1'b0;
      take_q <= 1'b0;
      vec_q  <= '0;
    end else begin
      // global enable: end of entry first, then set, then clear
      if (finish)
        gie_q <= 1'b0;
      else if (reti_i || gie_set_i)
        gie_q <= 1'b1;
      else if (gie_clr_i)
        gie_q <= 1'b0;

      // entry sequencing with index frozen until the fetch strobe
      if (take_q) begin
        if (vec_done_i) take_q <= 1'b0;
      end else if (gie_q && cand_any_i) begin
        take_q <= 1'b1;
        vec_q  <= cand_idx_i;
      end
    end
  end

  assign gie_o  = gie_q;
  assign take_o = take_q;
  assign vec_o  = vec_q;

  // R4: the enable only rises through a set or return strobe
  a_r4_gie_rise_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(gie_q) |-> $past(reti_i || gie_set_i));

  // R5: no entry starts while masked
  a_r5_take_needs_gie: assert property (@(posedge clk) disable iff (rst)
    $rose(take_q) |-> $past(gie_q));

  // R6: entry starts only with a pending enabled source
  a_r6_take_needs_cand: assert property (@(posedge clk) disable iff (rst)
    $rose(take_q) |-> $past(cand_any_i));

  // R7: index frozen throughout the entry
  a_r7_vec_hold: assert property (@(posedge clk) disable iff (rst)
    (take_q && $past(take_q)) |-> $stable(vec_q));

  // R8: fetch strobe ends entry and masks
  a_r8_done_masks: assert property (@(posedge clk) disable iff (rst)
    (take_q && vec_done_i) |=> (!take_q && !gie_q));

endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_SRC = irq_prio_pkg::SRC_COUNT,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] src_en_i,
  input  logic               ack_i,
  input  logic [IDX_W-1:0]   ack_idx_i,
  input  logic [NUM_SRC-1:0] pend_clr_i,
  input  logic               gie_set_i,
  input  logic               gie_clr_i,
  input  logic               reti_i,
  input  logic               vec_done_i,
  output logic               irq_take_o,
  output logic [IDX_W-1:0]   vec_idx_o,
  output logic               gie_o,
  output logic [NUM_SRC-1:0] pend_o
);

  logic [NUM_SRC-1:0] ack_hit;
  logic [NUM_SRC-1:0] clr_mask;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] cand;
  logic               cand_any;
  logic [IDX_W-1:0]   cand_idx;

  // decode of the indexed acknowledge; out-of-range indices hit nothing
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_ack
    assign ack_hit[g] = ack_i && (ack_idx_i == IDX_W'(g));
  end

  assign clr_mask = ack_hit | pend_clr_i;

  irq_pend_bank #(.N(NUM_SRC)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .req_i  (req_i),
    .clr_i  (clr_mask),
    .pend_o (pend)
  );

  assign cand = pend & src_en_i;

  irq_prio_pick #(.N(NUM_SRC), .W(IDX_W)) u_pick (
    .cand_i (cand),
    .any_o  (cand_any),
    .idx_o  (cand_idx)
  );

  irq_entry_ctl #(.W(IDX_W)) u_entry (
    .clk        (clk),
    .rst        (rst),
    .cand_any_i (cand_any),
    .cand_idx_i (cand_idx),
    .vec_done_i (vec_done_i),
    .reti_i     (reti_i),
    .gie_set_i  (gie_set_i),
    .gie_clr_i  (gie_clr_i),
    .gie_o      (gie_o),
    .take_o     (irq_take_o),
    .vec_o      (vec_idx_o)
  );

  assign pend_o = pend;

  // R6: the frozen index always names a source that exists
  a_r6_idx_in_range: assert property (@(posedge clk) disable iff (rst)
    irq_take_o |-> (int'(vec_idx_o) < NUM_SRC));

endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NS = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] req = '0, en = '0, pclr = '0;
  logic       ack = 1'b0;
  logic [2:0] ack_idx = '0;
  logic       gset = 1'b0, gclr = 1'b0, reti = 1'b0, vdone = 1'b0;

  logic       take, gie;
  logic [2:0] vec;
  logic [4:0] pend;

  int    total = 0, fails = 0;
  bit    run = 0, done = 0;
  string tag = "R1 reset";

  // reference state
  bit m_pend[NS], m_prev[NS], n_pend[NS];
  bit m_gie, m_take, n_gie, n_take;
  int m_vec, n_vec, best;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .req_i(req), .src_en_i(en), .ack_i(ack),
    .ack_idx_i(ack_idx), .pend_clr_i(pclr), .gie_set_i(gset),
    .gie_clr_i(gclr), .reti_i(reti), .vec_done_i(vdone),
    .irq_take_o(take), .vec_idx_o(vec), .gie_o(gie), .pend_o(pend)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NS; i++) begin m_pend[i] = 0; m_prev[i] = 0; end
      m_gie = 0; m_take = 0; m_vec = 0;
    end else begin
      best = -1;
      for (int i = 0; i < NS; i++)
        if (m_pend[i] && en[i] && i > best) best = i;
      for (int i = 0; i < NS; i++) begin
        if (req[i] && !m_prev[i]) n_pend[i] = 1;
        else if ((ack && int'(ack_idx) == i) || pclr[i]) n_pend[i] = 0;
        else n_pend[i] = m_pend[i];
        m_prev[i] = req[i];
      end
      n_gie = m_gie; n_take = m_take; n_vec = m_vec;
      if (m_take && vdone) n_gie = 0;
      else if (gset || reti) n_gie = 1;
      else if (gclr) n_gie = 0;
      if (m_take) begin
        if (vdone) n_take = 0;
      end else if (m_gie && best >= 0) begin
        n_take = 1; n_vec = best;
      end
      m_pend = n_pend; m_gie = n_gie; m_take = n_take; m_vec = n_vec;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (run) begin
      int mp;
      mp = 0;
      for (int i = 0; i < NS; i++) if (m_pend[i]) mp |= (1 << i);
      check("take", int'(take), int'(m_take));
      check("gie", int'(gie), int'(m_gie));
      check("pend", int'(pend), mp);
      if (m_take) check("vec", int'(vec), m_vec);
    end
  end

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
    ack = 0; pclr = '0; gset = 0; gclr = 0; reti = 0; vdone = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(3);
    rst = 0;
    run = 1;
    tag = "R1 reset";
    check("take", int'(take), 0); check("gie", int'(gie), 0);
    check("pend", int'(pend), 0); check("vec", int'(vec), 0);

    tag = "R5 masked";
    en = 5'h1F; req[2] = 1; tick(3);
    check("pend R2", int'(pend), 5'b00100);
    check("take R5", int'(take), 0);

    tag = "R4 set";
    gset = 1; tick(1);
    check("gie R4", int'(gie), 1);
    tag = "R6 entry"; tick(1);
    check("take R6", int'(take), 1); check("vec R6", int'(vec), 2);

    tag = "R7 hold";
    req[4] = 1; tick(3);
    check("vec R7", int'(vec), 2); check("take R7", int'(take), 1);

    tag = "R8 done";
    vdone = 1; tick(1);
    check("take R8", int'(take), 0); check("gie R8", int'(gie), 0);
    tag = "R3 ack";
    ack = 1; ack_idx = 2; tick(1);
    check("pend R3", int'(pend), 5'b10000);

    tag = "R9 nest";
    gset = 1; tick(2);
    check("take R9", int'(take), 1); check("vec R9", int'(vec), 4);
    vdone = 1; tick(1);
    ack = 1; ack_idx = 4; tick(1);
    tag = "R4 reti";
    reti = 1; tick(2);
    check("gie R4", int'(gie), 1);
    tag = "R2 held";
    check("take R2", int'(take), 0); check("pend R2", int'(pend), 0);

    tag = "R3 race";
    en = 5'b11101; req[1] = 1; tick(1);
    req[1] = 0; tick(1);
    pclr = 5'b00010; tick(1);
    req[1] = 1; ack = 1; ack_idx = 1; tick(1);
    check("pend R3", int'(pend), 5'b00010);
    ack = 1; ack_idx = 6; tick(1);
    check("pend R3 idx6", int'(pend), 5'b00010);

    tag = "R6 disabled";
    tick(2);
    check("take R6 dis", int'(take), 0);
    en = 5'h1F; tick(1);
    check("take R6", int'(take), 1); check("vec R6", int'(vec), 1);

    tag = "R8 override";
    vdone = 1; reti = 1; tick(1);
    check("gie R8", int'(gie), 0); check("take R8", int'(take), 0);
    tag = "R8 idle";
    gset = 1; ack = 1; ack_idx = 1; tick(2);
    vdone = 1; tick(1);
    check("gie R8 idle", int'(gie), 1);
    tag = "R4 prec";
    gclr = 1; gset = 1; tick(1);
    check("gie R4 both", int'(gie), 1);
    gclr = 1; tick(1);
    check("gie R4 clr", int'(gie), 0);

    tag = "random R2 R3 R4 R6 R7 R8";
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(3) == 0) req[$urandom_range(4)] ^= 1'b1;
      if ($urandom_range(15) == 0) en = 5'($urandom);
      ack = ($urandom_range(2) == 0);
      ack_idx = 3'($urandom);
      if ($urandom_range(19) == 0) pclr = 5'($urandom);
      gset = ($urandom_range(7) == 0);
      gclr = ($urandom_range(15) == 0);
      reti = ($urandom_range(15) == 0);
      vdone = ($urandom_range(3) == 0);
      tick(1);
    end

    run = 0;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule